// File: doc/BRIEF.md
# Speculative Store Holding Buffer

This block sits between a core's store path and a simple memory write port. Every store the core issues is parked in a small ring of entries. Each entry holds a word address, write data and byte-lane enables. A store stays in the ring until the core declares the current speculative region correct by pulsing a commit input. A rollback input instead throws away every store issued since the last commit, so those writes never reach memory.

A commit does not copy or move any entry. It only advances a boundary pointer, so it costs one clock and no data traffic. Committed stores leave the ring oldest first over a valid/ready write port, one per clock. Loads can look the ring up combinationally. The lookup returns the data of the youngest held store that fully covers the requested word, whether that store is committed or still speculative.

Top module: `store_gate_buf`

## Requirements
- R1: A store offered with `st_valid` is accepted when the ring is not full and `rollback` is low. An accepted store is never presented on the memory port before a commit that covers it.
- R2: A `commit` pulse makes every store accepted in earlier cycles releasable, and `mem_valid` is high in the cycle after the pulse. A store accepted in the same cycle as the pulse belongs to the next region and needs a later commit.
- R3: Releasable stores leave oldest first, one per clock in which `mem_valid` and `mem_ready` are both high. While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_data` and `mem_be` hold their values.
- R4: A `rollback` pulse discards every uncommitted store in one cycle, and none of them ever reaches the memory port. A store offered in the rollback cycle is discarded too.
- R5: A rollback leaves committed stores that have not yet drained in place, and they still drain in order.
- R6: When `commit` and `rollback` are high in the same cycle, the rollback takes effect and the commit is ignored.
- R7: The ring holds 8 entries. Occupancy is counted at the start of the cycle, so an entry freed by a drain in that same cycle does not count as free. When 8 entries are occupied, `st_stall` equals `st_valid` and the offered store is not accepted.
- R8: The load lookup is combinational. `ld_hit` is high when some held entry, committed or not, has `addr[31:2]` equal to `ld_addr[31:2]` and `be` equal to 4'b1111. `ld_data` is the data of the youngest such entry. Entries with partial enables never hit, and `ld_data` is 0 on a miss.
- R9: After synchronous reset the ring is empty: `mem_valid`, `st_stall` and `ld_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered this cycle |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte-lane enables |
| st_stall | output | 1 | Offered store refused, ring full |
| commit | input | 1 | Close the speculative region, release its stores |
| rollback | input | 1 | Discard all uncommitted stores |
| mem_valid | output | 1 | A committed store is presented |
| mem_ready | input | 1 | Memory takes the presented store |
| mem_addr | output | 32 | Presented store address |
| mem_data | output | 32 | Presented store data |
| mem_be | output | 4 | Presented store byte enables |
| ld_addr | input | 32 | Load lookup address |
| ld_hit | output | 1 | A fully covering held store exists |
| ld_data | output | 32 | Forwarded data from the youngest covering store |

## Verification
Holding, releasing and dropping are each driven with store bursts that are then followed by different pulses: a lone commit, a lone rollback, both together, and a rollback that lands while committed stores are still waiting behind a stalled memory port. Counting and ordering what reaches the port tells the region boundary apart from a plain queue. A store that arrives in the same cycle as a commit or a rollback shows which region the block puts it in. Filling all eight entries with the port blocked exposes off-by-one errors in the stall. The lookup is tried against the same word written twice, against a younger partial write, against an unaligned byte address and against a missing word, which separates youngest-wins from oldest-wins and exact-address matching from word-address matching.

// File: rtl/sgb_pkg.sv
package sgb_pkg;

    localparam int unsigned SGB_ADDR_W = 32;
    localparam int unsigned SGB_DATA_W = 32;
    localparam int unsigned SGB_BE_W   = SGB_DATA_W / 8;
    localparam int unsigned SGB_OFS_W  = $clog2(SGB_BE_W);

    typedef logic [SGB_ADDR_W-1:0] addr_t;
    typedef logic [SGB_DATA_W-1:0] data_t;
    typedef logic [SGB_BE_W-1:0]   be_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
        be_t   be;
    } st_entry_t;

    // Region action for one cycle; discard outranks release.
    typedef enum logic [1:0] {
        WIN_HOLD     = 2'd0,
        WIN_COMMIT   = 2'd1,
        WIN_ROLLBACK = 2'd2
    } win_op_e;

    function automatic win_op_e pick_win_op(input logic commit_i, input logic rollback_i);
        if (rollback_i)    return WIN_ROLLBACK;
        else if (commit_i) return WIN_COMMIT;
        else               return WIN_HOLD;
    endfunction

    function automatic logic same_word(input addr_t a, input addr_t b);
        return a[SGB_ADDR_W-1:SGB_OFS_W] == b[SGB_ADDR_W-1:SGB_OFS_W];
    endfunction

    function automatic logic covers_word(input be_t be);
        return &be;
    endfunction

endpackage

// File: rtl/sgb_ptr_ctrl.sv
module sgb_ptr_ctrl #(
    parameter int unsigned DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push_i,
    input  logic                     pop_i,
    input  sgb_pkg::win_op_e         win_op_i,
    output logic [$clog2(DEPTH):0]   head_o,
    output logic [$clog2(DEPTH):0]   tail_o,
    output logic [$clog2(DEPTH):0]   used_o,
    output logic                     full_o,
    output logic                     rel_avail_o
);
    import sgb_pkg::*;

    localparam int unsigned PW = $clog2(DEPTH);
    localparam logic [PW:0] CAP = (PW+1)'(DEPTH);

    // head: oldest held entry; cmt: first uncommitted entry; tail: next free slot.
    logic [PW:0] head_q, cmt_q, tail_q;
    logic [PW:0] push_inc, pop_inc;

    assign push_inc = {{PW{1'b0}}, push_i};
    assign pop_inc  = {{PW{1'b0}}, pop_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            cmt_q  <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + pop_inc;
            case (win_op_i)
                WIN_ROLLBACK: tail_q <= cmt_q;
                WIN_COMMIT: begin
                    cmt_q  <= tail_q;
                    tail_q <= tail_q + push_inc;
                end
                default: tail_q <= tail_q + push_inc;
            endcase
        end
    end

    assign head_o      = head_q;
    assign tail_o      = tail_q;
    assign used_o      = tail_q - head_q;
    assign full_o      = (used_o == CAP);
    assign rel_avail_o = (head_q != cmt_q);

endmodule

// File: rtl/sgb_entry_ram.sv
module sgb_entry_ram #(
    parameter int unsigned DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        we_i,
    input  logic [$clog2(DEPTH)-1:0]    waddr_i,
    input  sgb_pkg::st_entry_t          wdata_i,
    input  logic [$clog2(DEPTH)-1:0]    raddr_i,
    output sgb_pkg::st_entry_t          rdata_o,
    output sgb_pkg::st_entry_t          ents_o [DEPTH]
);
    import sgb_pkg::*;

    localparam int unsigned PW = $clog2(DEPTH);

    st_entry_t ents_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we_i && (waddr_i == PW'(g))) begin
                ents_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = ents_q[raddr_i];
    assign ents_o  = ents_q;

endmodule

// File: rtl/sgb_fwd_lookup.sv
module sgb_fwd_lookup #(
    parameter int unsigned DEPTH = 8
) (
    input  sgb_pkg::st_entry_t          ents_i [DEPTH],
    input  logic [$clog2(DEPTH)-1:0]    head_i,
    input  logic [$clog2(DEPTH):0]      used_i,
    input  sgb_pkg::addr_t              ld_addr_i,
    output logic                        hit_o,
    output sgb_pkg::data_t              data_o
);
    import sgb_pkg::*;

    localparam int unsigned PW = $clog2(DEPTH);

    // Walk from oldest to youngest so a later match overrides an earlier one.
    always_comb begin
        logic [PW-1:0] idx;
        hit_o  = 1'b0;
        data_o = '0;
        idx    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = head_i + PW'(i);
            if (((PW+1)'(i) < used_i) &&
                same_word(ents_i[idx].addr, ld_addr_i) &&
                covers_word(ents_i[idx].be)) begin
                hit_o  = 1'b1;
                data_o = ents_i[idx].data;
            end
        end
    end

endmodule

// File: rtl/store_gate_buf.sv
module store_gate_buf #(
    parameter int unsigned DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        st_valid,
    input  logic [31:0] st_addr,
    input  logic [31:0] st_data,
    input  logic [3:0]  st_be,
    output logic        st_stall,
    input  logic        commit,
    input  logic        rollback,
    output logic        mem_valid,
    input  logic        mem_ready,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_data,
    output logic [3:0]  mem_be,
    input  logic [31:0] ld_addr,
    output logic        ld_hit,
    output logic [31:0] ld_data
);
    import sgb_pkg::*;

    localparam int unsigned PW = $clog2(DEPTH);

    win_op_e     win_op;
    logic        full, rel_avail, accept, drain;
    logic [PW:0] head, tail, used;
    st_entry_t   new_ent, head_ent;
    st_entry_t   ents [DEPTH];

    assign win_op  = pick_win_op(commit, rollback);
    assign accept  = st_valid && !full && (win_op != WIN_ROLLBACK);
    assign drain   = rel_avail && mem_ready;
    assign new_ent = '{addr: st_addr, data: st_data, be: st_be};

    sgb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .push_i      (accept),
        .pop_i       (drain),
        .win_op_i    (win_op),
        .head_o      (head),
        .tail_o      (tail),
        .used_o      (used),
        .full_o      (full),
        .rel_avail_o (rel_avail)
    );

    sgb_entry_ram #(.DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .we_i    (accept),
        .waddr_i (tail[PW-1:0]),
        .wdata_i (new_ent),
        .raddr_i (head[PW-1:0]),
        .rdata_o (head_ent),
        .ents_o  (ents)
    );

    sgb_fwd_lookup #(.DEPTH(DEPTH)) u_fwd (
        .ents_i    (ents),
        .head_i    (head[PW-1:0]),
        .used_i    (used),
        .ld_addr_i (ld_addr),
        .hit_o     (ld_hit),
        .data_o    (ld_data)
    );

    assign st_stall  = st_valid && full;
    assign mem_valid = rel_avail;
    assign mem_addr  = head_ent.addr;
    assign mem_data  = head_ent.data;
    assign mem_be    = head_ent.be;

endmodule

// File: rtl/sgb_checker.sv
module sgb_checker #(
    parameter int unsigned DEPTH = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        st_valid,
    input logic        st_stall,
    input logic        commit,
    input logic        rollback,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_data,
    input logic [3:0]  mem_be
);
    localparam int unsigned CW = $clog2(DEPTH) + 1;

    // Independent occupancy model: speculative and releasable counts.
    logic [CW-1:0] spec_q, rel_q;
    logic [CW:0]   occ;
    logic          acc, drn;

    assign acc = st_valid && !st_stall && !rollback;
    assign drn = mem_valid && mem_ready;
    assign occ = {1'b0, spec_q} + {1'b0, rel_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_q <= '0;
            rel_q  <= '0;
        end else begin
            rel_q <= rel_q - CW'(drn) + ((commit && !rollback) ? spec_q : '0);
            if (rollback)    spec_q <= '0;
            else if (commit) spec_q <= CW'(acc);
            else             spec_q <= spec_q + CW'(acc);
        end
    end

    assert_gated_release_R1: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (rel_q != '0));

    assert_commit_releases_R2: assert property (@(posedge clk) disable iff (rst)
        (commit && !rollback && spec_q != '0) |=> mem_valid);

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

    assert_rollback_drops_R4: assert property (@(posedge clk) disable iff (rst)
        (rollback && !commit && rel_q == CW'(drn)) |=> !mem_valid);

    assert_keep_committed_R5: assert property (@(posedge clk) disable iff (rst)
        (rollback && rel_q > CW'(1)) |=> mem_valid);

    assert_rollback_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (commit && rollback && rel_q == '0) |=> !mem_valid);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        occ <= (CW+1)'(DEPTH));

    assert_stall_when_full_R7: assert property (@(posedge clk) disable iff (rst)
        st_stall |-> (st_valid && occ == (CW+1)'(DEPTH)));

endmodule

bind store_gate_buf sgb_checker #(.DEPTH(DEPTH)) u_sgb_chk (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .st_stall  (st_stall),
    .commit    (commit),
    .rollback  (rollback),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_be    (mem_be)
);

// File: tb/store_gate_buf_tb.sv
module store_gate_buf_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid, commit, rollback, mem_ready;
    logic [31:0] st_addr, st_data, ld_addr;
    logic [3:0]  st_be;
    logic        st_stall, mem_valid, ld_hit;
    logic [31:0] mem_addr, mem_data, ld_data;
    logic [3:0]  mem_be;

    int n_tests = 0;
    int n_fail  = 0;
    int log_n   = 0;
    logic [31:0] log_a [128];
    logic [31:0] log_d [128];

    always #10 clk = ~clk;

    store_gate_buf u_dut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
        .commit(commit), .rollback(rollback), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_be(mem_be), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data)
    );

    // Record each handshake at the falling edge; inputs are stable until the next rising edge.
    always @(negedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            if (log_n < 128) begin
                log_a[log_n] = mem_addr;
                log_d[log_n] = mem_data;
            end
            log_n++;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic sv, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input logic c, input logic r);
        st_valid = sv; st_addr = a; st_data = d; st_be = be;
        commit = c; rollback = r;
        @(posedge clk); #2;
        st_valid = 1'b0; commit = 1'b0; rollback = 1'b0;
    endtask

    task automatic push(input logic [31:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 4'hF, 1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, '0, '0, 1'b0, 1'b0);
    endtask

    task automatic lookup(input logic [31:0] a);
        ld_addr = a; #1;
    endtask

    task automatic t_reset;
        chk("R9", "mem_valid after reset", {31'd0, mem_valid}, 32'd0);
        chk("R9", "st_stall after reset", {31'd0, st_stall}, 32'd0);
        lookup(32'h0);
        chk("R9", "ld_hit after reset", {31'd0, ld_hit}, 32'd0);
    endtask

    task automatic t_hold_then_commit;
        int base = log_n;
        mem_ready = 1'b1;
        for (int k = 0; k < 3; k++) push(32'h100 + 32'(k*4), 32'hA000_0000 + 32'(k));
        idle(4);
        chk("R1", "writes before commit", 32'(log_n - base), 0);
        chk("R1", "mem_valid before commit", {31'd0, mem_valid}, 32'd0);
        lookup(32'h104);
        chk("R8", "hit on speculative store", {31'd0, ld_hit}, 32'd1);
        chk("R8", "data on speculative store", ld_data, 32'hA000_0001);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0);
        chk("R2", "mem_valid cycle after commit", {31'd0, mem_valid}, 32'd1);
        chk("R3", "oldest presented first", mem_addr, 32'h100);
        idle(4);
        chk("R3", "drained count", 32'(log_n - base), 32'd3);
        for (int k = 0; k < 3; k++) begin
            chk("R3", "drain order addr", log_a[base+k], 32'h100 + 32'(k*4));
            chk("R3", "drain order data", log_d[base+k], 32'hA000_0000 + 32'(k));
        end
        chk("R3", "empty after drain", {31'd0, mem_valid}, 32'd0);
    endtask

    task automatic t_backpressure;
        int base = log_n;
        mem_ready = 1'b0;
        push(32'h300, 32'hB000_0000);
        push(32'h304, 32'hB000_0001);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0);
        idle(3);
        chk("R3", "valid held while blocked", {31'd0, mem_valid}, 32'd1);
        chk("R3", "addr held while blocked", mem_addr, 32'h300);
        chk("R3", "data held while blocked", mem_data, 32'hB000_0000);
        chk("R3", "no write while blocked", 32'(log_n - base), 32'd0);
        mem_ready = 1'b1;
        idle(3);
        chk("R3", "drained after unblock", 32'(log_n - base), 32'd2);
        chk("R3", "second drained addr", log_a[base+1], 32'h304);
    endtask

    task automatic t_rollback;
        int base = log_n;
        mem_ready = 1'b1;
        for (int k = 0; k < 3; k++) push(32'h400 + 32'(k*4), 32'hC000_0000 + 32'(k));
        // store offered in the rollback cycle
        drive(1'b1, 32'h40C, 32'hC000_0003, 4'hF, 1'b0, 1'b1);
        lookup(32'h40C);
        chk("R4", "store in rollback cycle dropped", {31'd0, ld_hit}, 32'd0);
        lookup(32'h400);
        chk("R4", "speculative store dropped", {31'd0, ld_hit}, 32'd0);
        idle(2);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0);
        idle(3);
        chk("R4", "no dropped store reaches memory", 32'(log_n - base), 32'd0);
        chk("R4", "mem_valid low after rollback", {31'd0, mem_valid}, 32'd0);
    endtask

    task automatic t_keep_committed;
        int base = log_n;
        mem_ready = 1'b0;
        push(32'h500, 32'hD000_0000);
        push(32'h504, 32'hD000_0001);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0);
        push(32'h508, 32'hD000_0002);
        push(32'h50C, 32'hD000_0003);
        drive(1'b0, '0, '0, '0, 1'b0, 1'b1);
        chk("R5", "committed still presented", {31'd0, mem_valid}, 32'd1);
        mem_ready = 1'b1;
        idle(4);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0);
        idle(2);
        chk("R5", "only committed drained", 32'(log_n - base), 32'd2);
        chk("R5", "first kept addr", log_a[base], 32'h500);
        chk("R5", "second kept addr", log_a[base+1], 32'h504);
    endtask

    task automatic t_both;
        int base = log_n;
        mem_ready = 1'b1;
        push(32'h600, 32'hE000_0000);
        push(32'h604, 32'hE000_0001);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b1);
        idle(3);
        chk("R6", "rollback beats commit", 32'(log_n - base), 32'd0);
        push(32'h608, 32'hE000_0002);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0);
        idle(3);
        chk("R6", "later store still works", 32'(log_n - base), 32'd1);
        chk("R6", "later store addr", log_a[base], 32'h608);
    endtask

    task automatic t_window;
        int base = log_n;
        mem_ready = 1'b1;
        push(32'h700, 32'hF000_0000);
        drive(1'b1, 32'h704, 32'hF000_0001, 4'hF, 1'b1, 1'b0);
        idle(3);
        chk("R2", "only earlier store released", 32'(log_n - base), 32'd1);
        chk("R2", "released store addr", log_a[base], 32'h700);
        chk("R2", "same-cycle store still held", {31'd0, mem_valid}, 32'd0);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0);
        idle(3);
        chk("R2", "second commit releases it", 32'(log_n - base), 32'd2);
        chk("R2", "second released addr", log_a[base+1], 32'h704);
    endtask

    task automatic t_full;
        int base = log_n;
        mem_ready = 1'b0;
        for (int k = 0; k < 7; k++) push(32'h800 + 32'(k*4), 32'h1000_0000 + 32'(k));
        st_valid = 1'b1; st_addr = 32'h81C; st_data = 32'h1000_0007; st_be = 4'hF; #1;
        chk("R7", "no stall with 7 held", {31'd0, st_stall}, 32'd0);
        @(posedge clk); #2;
        st_valid = 1'b1; st_addr = 32'h820; st_data = 32'h1000_0008; #1;
        chk("R7", "stall with 8 held", {31'd0, st_stall}, 32'd1);
        @(posedge clk); #2;
        st_valid = 1'b0;
        lookup(32'h820);
        chk("R7", "refused store not held", {31'd0, ld_hit}, 32'd0);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0);
        mem_ready = 1'b1;
        idle(10);
        chk("R7", "eight drained", 32'(log_n - base), 32'd8);
        chk("R7", "last drained addr", log_a[base+7], 32'h81C);
    endtask

    task automatic t_lookup;
        int base = log_n;
        mem_ready = 1'b0;
        push(32'h200, 32'h0000_0011);
        push(32'h200, 32'h0000_0022);
        drive(1'b1, 32'h200, 32'h0000_0033, 4'h3, 1'b0, 1'b0);
        push(32'h204, 32'h0000_0044);
        lookup(32'h200);
        chk("R8", "youngest full match", ld_data, 32'h0000_0022);
        lookup(32'h202);
        chk("R8", "byte offset ignored hit", {31'd0, ld_hit}, 32'd1);
        chk("R8", "byte offset ignored data", ld_data, 32'h0000_0022);
        lookup(32'h204);
        chk("R8", "neighbour word", ld_data, 32'h0000_0044);
        lookup(32'h208);
        chk("R8", "miss hit flag", {31'd0, ld_hit}, 32'd0);
        chk("R8", "miss data zero", ld_data, 32'd0);
        drive(1'b0, '0, '0, '0, 1'b1, 1'b0);
        lookup(32'h200);
        chk("R8", "committed undrained forwards", ld_data, 32'h0000_0022);
        mem_ready = 1'b1;
        idle(6);
        lookup(32'h200);
        chk("R8", "no hit after drain", {31'd0, ld_hit}, 32'd0);
        chk("R8", "all four drained", 32'(log_n - base), 32'd4);
    endtask

    initial begin
        #4_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; st_valid = 1'b0; commit = 1'b0; rollback = 1'b0;
        mem_ready = 1'b0; st_addr = '0; st_data = '0; st_be = '0; ld_addr = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        t_reset();
        t_hold_then_commit();
        t_backpressure();
        t_rollback();
        t_keep_committed();
        t_both();
        t_window();
        t_full();
        t_lookup();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule